// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

The block is a register-mapped timer peripheral with four independent down-counters. Each counter holds a load register, a live count, a control register and a background value. A load write moves the count at once. A background write only takes effect the next time the counter wraps. Each counter runs in one of three modes: free-running, periodic reload or one-shot. It can decrement on every clock or once every 16 or 256 clocks. It can also be limited to 16 bits.

Software sees the block through a plain synchronous bus: address, write enable, write data and registered read data. When a counter reaches zero it sets its raw status bit. One shared group of registers masks these bits, reports them and clears them. A single registered interrupt line reports any raw bit that is also unmasked.

Top module: `quad_downtimer`

## Requirements
- R1: After a synchronous reset every register reads 0 and `irq` is low.
- R2: The address map is as follows. Channel n (0..3) occupies the group at 0x10+0x10·n, with load at +0x0, live count at +0x4, control at +0x8 and background at +0xC. The shared registers are mask (0x00, read/write), raw status (0x04), masked status (0x08, raw AND mask) and clear (0x0C, reads 0). Bit n of each shared register belongs to channel n. `bus_rdata` shows the addressed register one clock after the address is presented. Unaligned or unmapped addresses read 0 and ignore writes.
- R3: The control bits are: bit 7 enable, bit 6 periodic, bit 1 wide (32-bit when set, 16-bit when clear) and bit 0 one-shot. While bit 7 is clear the count does not change except through a load write.
- R4: Control bits 3:2 select the prescale: 00 and 11 give 1, 01 gives 16, 10 gives 256. A control write at edge E restarts the divider, and the first decrement happens at edge E+divisor.
- R5: A load write replaces the count in the same edge, masked to the active width. It takes precedence over a decrement, and the load register reads back the full written value.
- R6: When a decrement makes the count zero, the channel's raw bit is set on that same edge.
- R7: In one-shot mode a counter at zero stays at zero. One-shot takes priority over bit 6.
- R8: In periodic mode, the decrement step taken at zero reloads the background value, masked to the width. Writing the background register does not change the count.
- R9: In free-running mode the step taken at zero wraps to 0xFFFF in 16-bit mode and to 0xFFFFFFFF in 32-bit mode.
- R10: Writing 1s to the clear register clears those raw bits. A raw bit that is set in the same edge stays set.
- R11: `irq` is registered and goes high one clock after any raw bit is high with its mask bit also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
Directed sequences put one channel at a time through each mode. One-shot is tried with a small load, periodic with prescale 16 and a background value different from the load, free-running with a 16-bit wrap, and prescale 256 followed by the reserved code. Polling the live count every clock separates a divider restart error from a reload-source error or a wrong wrap value. A long random phase then mixes control, load, background, mask and clear writes across all channels, with small counts, so that zero crossings, same-edge set and clear, and load-over-decrement collisions all occur. Every read and the interrupt line are compared with a bench model on each clock.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  localparam int CB_EN   = 7;
  localparam int CB_PER  = 6;
  localparam int CB_PSH  = 3;
  localparam int CB_PSL  = 2;
  localparam int CB_WIDE = 1;
  localparam int CB_ONCE = 0;
  localparam int CTRL_W  = 8;
  localparam int PS_W    = 8;

  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_BG    = 2'd3
  } chsel_e;

  // terminal value of the prescale divider for each code
  function automatic logic [PS_W-1:0] ps_limit(input logic [1:0] code);
    case (code)
      2'b01:   ps_limit = PS_W'(15);
      2'b10:   ps_limit = PS_W'(255);
      default: ps_limit = '0;
    endcase
  endfunction
endpackage

// File: rtl/qdt_prescale.sv
module qdt_prescale
  import qdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       enable,
  input  logic [1:0] code,
  output logic       tick
);
  logic [PS_W-1:0] div_q;
  logic            at_lim;

  assign at_lim = (div_q == ps_limit(code));
  assign tick   = enable && at_lim && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (enable) begin
      div_q <= at_lim ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
  import qdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int NW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              ctrl_we,
  input  logic              bg_we,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     count,
  output logic [DW-1:0]     ld_val,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DW-1:0]     bg_val,
  output logic              hit
);
  localparam logic [DW-1:0] FULL_M   = {DW{1'b1}};
  localparam logic [DW-1:0] NARROW_M = DW'({NW{1'b1}});

  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     cnt_q, cnt_n, ld_q, bg_q, wmask;
  logic              tick;

  qdt_prescale u_ps (
    .clk     (clk),
    .rst     (rst),
    .restart (ctrl_we),
    .enable  (ctrl_q[CB_EN]),
    .code    (ctrl_q[CB_PSH:CB_PSL]),
    .tick    (tick)
  );

  assign wmask = ctrl_q[CB_WIDE] ? FULL_M : NARROW_M;

  always_comb begin
    cnt_n = cnt_q;
    hit   = 1'b0;
    if (ld_we) begin
      cnt_n = wdata & wmask;
    end else if (tick) begin
      if (cnt_q == '0) begin
        if (ctrl_q[CB_ONCE])      cnt_n = cnt_q;
        else if (ctrl_q[CB_PER])  cnt_n = bg_q & wmask;
        else                      cnt_n = wmask;
      end else begin
        cnt_n = (cnt_q - 1'b1) & wmask;
        hit   = (cnt_n == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      ld_q   <= '0;
      bg_q   <= '0;
    end else begin
      cnt_q <= cnt_n;
      if (ld_we)   ld_q   <= wdata;
      if (ctrl_we) ctrl_q <= wdata[CTRL_W-1:0];
      if (bg_we)   bg_q   <= wdata;
    end
  end

  assign count  = cnt_q;
  assign ld_val = ld_q;
  assign ctrl   = ctrl_q;
  assign bg_val = bg_q;
endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mask_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] hit,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] raw,
  output logic           irq
);
  logic [NCH-1:0] mask_q, raw_q, clr_bits;
  logic           irq_q;

  assign clr_bits = clr_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      raw_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wbits;
      raw_q <= (raw_q & ~clr_bits) | hit;
      irq_q <= |(raw_q & mask_q);
    end
  end

  assign mask = mask_q;
  assign raw  = raw_q;
  assign irq  = irq_q;
endmodule

// File: rtl/quad_downtimer.sv
module quad_downtimer
  import qdt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int BW = AW - 4;

  logic [BW-1:0]                  blk;
  chsel_e                         sel;
  logic                           aligned;
  logic [NCH-1:0]                 hit_v, raw_q, mask_q;
  logic [NCH-1:0][DW-1:0]         cnt_all, ld_all, bg_all;
  logic [NCH-1:0][CTRL_W-1:0]     ctrl_all;
  logic [DW-1:0]                  rd_n, rd_q;
  logic                           shr_we;

  assign blk     = bus_addr[AW-1:4];
  assign sel     = chsel_e'(bus_addr[3:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign shr_we  = bus_we && aligned && (blk == '0);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic ch_we;
    assign ch_we = bus_we && aligned && (blk == BW'(n + 1));
    qdt_channel #(.DW(DW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .ld_we   (ch_we && sel == SEL_LOAD),
      .ctrl_we (ch_we && sel == SEL_CTRL),
      .bg_we   (ch_we && sel == SEL_BG),
      .wdata   (bus_wdata),
      .count   (cnt_all[n]),
      .ld_val  (ld_all[n]),
      .ctrl    (ctrl_all[n]),
      .bg_val  (bg_all[n]),
      .hit     (hit_v[n])
    );
  end

  qdt_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .mask_we (shr_we && sel == SEL_LOAD),
    .clr_we  (shr_we && sel == SEL_BG),
    .wbits   (bus_wdata[NCH-1:0]),
    .hit     (hit_v),
    .mask    (mask_q),
    .raw     (raw_q),
    .irq     (irq)
  );

  always_comb begin
    rd_n = '0;
    if (aligned) begin
      if (blk == '0) begin
        case (sel)
          SEL_LOAD:  rd_n = DW'(mask_q);
          SEL_COUNT: rd_n = DW'(raw_q);
          SEL_CTRL:  rd_n = DW'(raw_q & mask_q);
          default:   rd_n = '0;
        endcase
      end else begin
        for (int n = 0; n < NCH; n++) begin
          if (blk == BW'(n + 1)) begin
            case (sel)
              SEL_LOAD:  rd_n = ld_all[n];
              SEL_COUNT: rd_n = cnt_all[n];
              SEL_CTRL:  rd_n = DW'(ctrl_all[n]);
              default:   rd_n = bg_all[n];
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_n;
  end

  assign bus_rdata = rd_q;
endmodule

// File: rtl/qdt_checker.sv
module qdt_checker #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_we,
  input logic [DW-1:0]          bus_rdata,
  input logic                   irq,
  input logic [NCH-1:0][DW-1:0] cnt_all,
  input logic [NCH-1:0][7:0]    ctrl_all,
  input logic [NCH-1:0]         raw_q,
  input logic [NCH-1:0]         mask_q
);
  localparam logic [DW-1:0] FULL_M   = {DW{1'b1}};
  localparam logic [DW-1:0] NARROW_M = DW'(16'hFFFF);
  localparam logic [DW-1:0] ONE      = DW'(1);

  for (genvar n = 0; n < NCH; n++) begin : g_c
    logic ld_w;
    assign ld_w = bus_we && (bus_addr == AW'(16 * (n + 1)));

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_all[n][7] && !ld_w) |=> $stable(cnt_all[n])); // R3

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
      (!ld_w && cnt_all[n] != '0) |=> ((cnt_all[n] == $past(cnt_all[n])) ||
        (cnt_all[n] == (($past(cnt_all[n]) - ONE) & ($past(ctrl_all[n][1]) ? FULL_M : NARROW_M))))); // R3

    AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (rst)
      (ctrl_all[n][0] && cnt_all[n] == '0 && !ld_w) |=> (cnt_all[n] == '0)); // R7

    AST_RAW_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      $rose(raw_q[n]) |-> (cnt_all[n] == '0)); // R6
  end

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
    (|(raw_q & mask_q)) |=> irq); // R11

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(raw_q & mask_q)) |=> !irq); // R11

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == AW'(12)) |=> (bus_rdata == '0)); // R10
endmodule

bind quad_downtimer qdt_checker #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cnt_all   (cnt_all),
  .ctrl_all  (ctrl_all),
  .raw_q     (raw_q),
  .mask_q    (mask_q)
);

// File: tb/quad_downtimer_tb.sv
module quad_downtimer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  quad_downtimer u_dut (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_we (bus_we),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
  );

  always #4 clk = ~clk;

  // reference model built from the requirements
  logic [31:0] m_ld [4];
  logic [31:0] m_cnt[4];
  logic [31:0] m_bg [4];
  logic [7:0]  m_ctl[4];
  int          m_pc [4];
  logic [3:0]  m_raw, m_mask;
  logic [31:0] m_exp_rd;
  logic        m_exp_irq;

  function automatic int f_lim(input logic [1:0] c);
    return (c == 2'b01) ? 15 : (c == 2'b10) ? 255 : 0;
  endfunction

  function automatic logic [31:0] f_wm(input logic [7:0] c);
    return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] f_read(input logic [7:0] a);
    int b = int'(a[7:4]);
    if (a[1:0] != 2'b00) return 32'h0;
    if (b == 0) begin
      case (a[3:2])
        2'd0: return {28'h0, m_mask};
        2'd1: return {28'h0, m_raw};
        2'd2: return {28'h0, m_raw & m_mask};
        default: return 32'h0;
      endcase
    end
    if (b > 4) return 32'h0;
    case (a[3:2])
      2'd0: return m_ld[b-1];
      2'd1: return m_cnt[b-1];
      2'd2: return {24'h0, m_ctl[b-1]};
      default: return m_bg[b-1];
    endcase
  endfunction

  function automatic string f_tag(input logic [7:0] a);
    if (a >= 8'h50) return "R2";
    if (a[7:4] == 4'h0) begin
      case (a[3:2])
        2'd0: return "R11";
        2'd1: return "R6";
        2'd2: return "R11";
        default: return "R10";
      endcase
    end
    case (a[3:2])
      2'd0: return "R5";
      2'd1: return "R3";
      2'd2: return "R3";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    logic       ldw, ctw, bgw, tk;
    logic [3:0] hitv, clr;
    logic [31:0] wm;
    if (rst) begin
      for (int n = 0; n < 4; n++) begin
        m_ld[n] = 0; m_cnt[n] = 0; m_bg[n] = 0; m_ctl[n] = 0; m_pc[n] = 0;
      end
      m_raw = 0; m_mask = 0; m_exp_rd = 0; m_exp_irq = 0;
    end else begin
      m_exp_rd  = f_read(bus_addr);
      m_exp_irq = |(m_raw & m_mask);
      hitv = 4'h0;
      for (int n = 0; n < 4; n++) begin
        ldw = bus_we && bus_addr == 8'(16 * (n + 1));
        ctw = bus_we && bus_addr == 8'(16 * (n + 1) + 8);
        bgw = bus_we && bus_addr == 8'(16 * (n + 1) + 12);
        tk  = m_ctl[n][7] && (m_pc[n] == f_lim(m_ctl[n][3:2])) && !ctw;
        if (ctw) m_pc[n] = 0;
        else if (m_ctl[n][7]) m_pc[n] = (m_pc[n] == f_lim(m_ctl[n][3:2])) ? 0 : m_pc[n] + 1;
        wm = f_wm(m_ctl[n]);
        if (ldw) m_cnt[n] = bus_wdata & wm;
        else if (tk) begin
          if (m_cnt[n] == 0) begin
            if (m_ctl[n][0])      m_cnt[n] = 0;
            else if (m_ctl[n][6]) m_cnt[n] = m_bg[n] & wm;
            else                  m_cnt[n] = wm;
          end else begin
            m_cnt[n] = (m_cnt[n] - 1) & wm;
            if (m_cnt[n] == 0) hitv[n] = 1'b1;
          end
        end
        if (ldw) m_ld[n]  = bus_wdata;
        if (ctw) m_ctl[n] = bus_wdata[7:0];
        if (bgw) m_bg[n]  = bus_wdata;
      end
      clr = (bus_we && bus_addr == 8'h0C) ? bus_wdata[3:0] : 4'h0;
      m_raw = (m_raw & ~clr) | hitv;
      if (bus_we && bus_addr == 8'h00) m_mask = bus_wdata[3:0];
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk({31'h0, irq}, {31'h0, m_exp_irq}, "R11");
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus_addr = a;
    cyc();
    chk(bus_rdata, m_exp_rd, tag);
  endtask

  task automatic rdl(input logic [7:0] a, input logic [31:0] lit, input string tag);
    bus_addr = a;
    cyc();
    chk(bus_rdata, lit, tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0051_7EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state of all mapped registers and the interrupt
    for (int a = 0; a < 8'h50; a += 4) rdl(8'(a), 32'h0, "R1");
    chk({31'h0, irq}, 32'h0, "R1");

    // R7 / R6: one-shot, divide by 1, stops at zero
    wr(8'h10, 32'd3);
    wr(8'h18, 32'h83);
    for (int i = 0; i < 6; i++) rd(8'h14, "R7");
    rdl(8'h14, 32'h0, "R7");
    rdl(8'h04, 32'h1, "R6");

    // R9: free-running 16-bit wrap
    wr(8'h30, 32'd1);
    wr(8'h38, 32'h80);
    rdl(8'h34, 32'h1, "R9");
    rdl(8'h34, 32'h0, "R9");
    rdl(8'h34, 32'h0000_FFFF, "R9");

    // R8 / R4: periodic, divide by 16, reload from background
    wr(8'h2C, 32'd2);
    wr(8'h20, 32'd1);
    wr(8'h28, 32'hC6);
    for (int i = 0; i < 70; i++) rd(8'h24, "R8");
    wr(8'h2C, 32'd7);
    rd(8'h24, "R8");
    for (int i = 0; i < 40; i++) rd(8'h24, "R4");

    // R4: divide by 256, then reserved code 11
    wr(8'h40, 32'd5);
    wr(8'h48, 32'h8A);
    for (int i = 0; i < 600; i++) rd(8'h44, "R4");
    wr(8'h48, 32'h8E);
    for (int i = 0; i < 12; i++) rd(8'h44, "R4");

    // R3: disable freezes the count
    wr(8'h28, 32'h0);
    for (int i = 0; i < 20; i++) rd(8'h24, "R3");

    // R5: load takes effect at once, masked to width
    wr(8'h40, 32'hABCD_0123);
    rd(8'h44, "R5");
    rdl(8'h40, 32'hABCD_0123, "R5");

    // R11 / R10: mask, masked status, clear
    wr(8'h00, 32'hF);
    rd(8'h08, "R11");
    rd(8'h08, "R11");
    wr(8'h0C, 32'hF);
    rd(8'h04, "R10");
    rd(8'h0C, "R10");
    rdl(8'h54, 32'h0, "R2");

    // random mixed traffic
    for (int i = 0; i < 30000; i++) begin
      int r  = int'($urandom % 10);
      int ch = int'($urandom % 4);
      int rg = int'($urandom % 4);
      logic [7:0]  a;
      logic [31:0] d;
      if (r < 3) begin
        if (($urandom % 5) == 0) begin
          a = (($urandom % 2) == 0) ? 8'h00 : 8'h0C;
          d = $urandom;
        end else begin
          a = 8'(16 * (ch + 1) + 4 * rg);
          d = $urandom;
          if (rg == 2) begin
            d = {24'h0, ($urandom % 8 != 0), 1'($urandom), 2'b00,
                 (($urandom % 6 == 0) ? 2'b10 : 2'($urandom % 2)),
                 1'($urandom), 1'($urandom)};
            if ($urandom % 7 == 0) d[3:2] = 2'b11;
          end else if (rg != 1 && ($urandom % 8 != 0)) begin
            d = $urandom % 40;
          end
        end
        wr(a, d);
      end else if (r == 3) begin
        a = 8'(8'h50 + 4 * ($urandom % 44));
        rd(a, "R2");
      end else begin
        a = (($urandom % 4) == 0) ? 8'(4 * ($urandom % 4)) : 8'(16 * (ch + 1) + 4 * rg);
        rd(a, f_tag(a));
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule